// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Output Sequencer

This block is the digital half of a 16-bit successive-approximation converter's three-wire serial port. A host drives an active-low chip select and a data clock. The block answers on a data line that can be tri-stated, which is shown here as a data bit plus an output enable. A parallel result input stands in for the analog core. The block copies that input into a holding register when the sample window closes, so the core may change it afterwards without harm.

Pulling chip select low starts a cycle. For the first four falling data-clock edges the output stays undriven while the input is sampled. The fifth falling edge enables the output and drives a single low null bit. The word then goes out most significant bit first. The same word follows a second time, least significant bit first, and after that the output tri-states and stays idle. Raising chip select ends the cycle at once, at any point, and puts the block in full shutdown. A separate status shows when the analog section may power down.

Chip select and the data clock come from the host and are asynchronous to the block's own system clock. Each passes through a two-flop synchroniser, and data-clock falling edges are detected on the system clock. No clock is gated. The outputs therefore follow the host pins after a latency of three system clock cycles.

Top module: `sar_serial_seq`

## Requirements
- R1: A high-to-low change of chip select starts a cycle: the shutdown flag and the analog power-down flag both drop, and the output enable stays low.
- R2: During the first four falling data-clock edges of a cycle the output enable stays low (sample window).
- R3: On the fifth falling edge the output enable rises and the data bit is 0 (null bit).
- R4: Falling edges 6 to 21 present result bits 15 down to 0, one bit per edge.
- R5: Falling edges 22 to 36 present result bits 1 up to 15. From edge 37 on, the output enable is low and further edges change nothing.
- R6: With chip select high the output enable is low and the shutdown flag is high. After a finished cycle, more edges with chip select held low start nothing. A new cycle needs chip select to go high and then low again.
- R7: Raising chip select in the middle of a word aborts the cycle at once (short cycling). The next cycle then runs normally.
- R8: The analog power-down flag is high while chip select is high and from the 21st falling edge of a cycle onward. The shutdown flag is high only while chip select is high.
- R9: The word is sent unchanged in straight binary: input 0x0000 gives all zeros and 0xFFFF gives all ones.
- R10: The result input is captured on the fifth falling edge. Changes on it after that edge do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the data clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Host chip select, active low; high means shutdown |
| sclk | input | 1 | Host data clock; bits change on its falling edges |
| result_in | input | 16 | Parallel conversion result from the analog core |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for the data line (0 = high impedance) |
| analog_pd | output | 1 | Analog section may be powered down |
| full_sd | output | 1 | Whole block is in shutdown |

## Verification
The bench goes after these edges:
- **Sample to null handover.** A controller that is off by one edge would drive during sampling or send a non-zero null bit.
- **Seam between the two word orders.** A design that re-sends bit 0 at edge 22 shifts the whole LSB-first part by one bit.
- **End of the repeat.** A design that fails to stop would keep the line driven, or would start a fresh cycle while chip select stays low.
- **Short cycles at several edges.** These must drop the enable, and the cycle after them must still run from the start.
- **Result input after capture.** The bench inverts the input right after the null bit. A design that does not hold the captured word would send the inverted bits.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_NULL   = 3'd2,
    PH_MSB    = 3'd3,
    PH_LSB    = 3'd4,
    PH_DONE   = 3'd5
  } phase_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SAMPLE_EDGES = 5,
  parameter int CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sclk_s,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             latch_en
);

  localparam logic [CNT_W-1:0] NULL_AT  = CNT_W'(SAMPLE_EDGES);
  localparam logic [CNT_W-1:0] MSB_END  = CNT_W'(SAMPLE_EDGES + DATA_W);
  localparam logic [CNT_W-1:0] LSB_END  = CNT_W'(SAMPLE_EDGES + 2*DATA_W - 1);

  logic   sclk_d;
  logic   fall;
  phase_t phase_n;
  logic [CNT_W-1:0] cnt_n;

  function automatic phase_t phase_of(input logic [CNT_W-1:0] k);
    if (k < NULL_AT)       return PH_SAMPLE;
    else if (k == NULL_AT) return PH_NULL;
    else if (k <= MSB_END) return PH_MSB;
    else if (k <= LSB_END) return PH_LSB;
    else                   return PH_DONE;
  endfunction

  assign fall = sclk_d & ~sclk_s;

  always_comb begin
    phase_n  = phase;
    cnt_n    = cnt;
    latch_en = 1'b0;
    if (cs_s) begin
      phase_n = PH_OFF;
      cnt_n   = '0;
    end else if (phase == PH_OFF) begin
      phase_n = PH_SAMPLE;
    end else if (fall && (phase != PH_DONE)) begin
      cnt_n    = cnt + 1'b1;
      phase_n  = phase_of(cnt_n);
      latch_en = (cnt_n == NULL_AT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OFF;
      cnt    <= '0;
      sclk_d <= 1'b0;
    end else begin
      phase  <= phase_n;
      cnt    <= cnt_n;
      sclk_d <= sclk_s;
    end
  end

endmodule

// File: rtl/sar_shift.sv
module sar_shift
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SAMPLE_EDGES = 5,
  parameter int CNT_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [DATA_W-1:0] result_in,
  input  phase_t            phase,
  input  logic [CNT_W-1:0]  cnt,
  output logic              dout
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(SAMPLE_EDGES + DATA_W);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_n;
  logic [CNT_W-1:0]  msb_idx;
  logic [CNT_W-1:0]  lsb_idx;

  always_comb begin
    word_n = word_q;
    if (latch_en) begin
      word_n = result_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_n;
    end
  end

  assign msb_idx = BASE - cnt;
  assign lsb_idx = cnt - BASE;

  always_comb begin
    case (phase)
      PH_MSB:  dout = word_q[msb_idx[IDX_W-1:0]];
      PH_LSB:  dout = word_q[lsb_idx[IDX_W-1:0]];
      default: dout = 1'b0;
    endcase
  end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SAMPLE_EDGES = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] result_in,
  output logic              dout,
  output logic              dout_oe,
  output logic              analog_pd,
  output logic              full_sd
);

  localparam int CNT_W = $clog2(SAMPLE_EDGES + 2*DATA_W + 1);
  localparam logic [CNT_W-1:0] PD_AT = CNT_W'(SAMPLE_EDGES + DATA_W);

  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic             cs_s;
  logic             sclk_s;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             latch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

  sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
    .clk(clk), .rst_n(rst_int_n), .d(cs_n), .q(cs_s)
  );

  sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sclk_sync (
    .clk(clk), .rst_n(rst_int_n), .d(sclk), .q(sclk_s)
  );

  sar_seq_ctrl #(
    .DATA_W(DATA_W), .SAMPLE_EDGES(SAMPLE_EDGES), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cs_s(cs_s), .sclk_s(sclk_s),
    .phase(phase), .cnt(cnt), .latch_en(latch_en)
  );

  sar_shift #(
    .DATA_W(DATA_W), .SAMPLE_EDGES(SAMPLE_EDGES), .CNT_W(CNT_W)
  ) i_shift (
    .clk(clk), .rst_n(rst_int_n), .latch_en(latch_en), .result_in(result_in),
    .phase(phase), .cnt(cnt), .dout(dout)
  );

  assign dout_oe   = (phase == PH_NULL) || (phase == PH_MSB) || (phase == PH_LSB);
  assign full_sd   = (phase == PH_OFF);
  assign analog_pd = full_sd || (cnt >= PD_AT);

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic dout,
  input logic dout_oe,
  input logic analog_pd,
  input logic full_sd
);

  a_r6_cs_high_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !dout_oe);

  a_r6_cs_high_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> full_sd);

  a_r3_null_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);

  a_r8_shutdown_implies_pd: assert property (@(posedge clk) disable iff (!rst_n)
    full_sd |-> (analog_pd && !dout_oe));

  a_r5_done_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (analog_pd && !full_sd && !dout_oe) |=> !dout_oe);

endmodule

bind sar_serial_seq sar_serial_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .dout(dout),
  .dout_oe(dout_oe), .analog_pd(analog_pd), .full_sd(full_sd)
);

// File: tb/test_sar_serial_seq.sv
module test_sar_serial_seq;

  localparam int HALF = 8;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic [15:0] result_in;
  logic        dout;
  logic        dout_oe;
  logic        analog_pd;
  logic        full_sd;

  int n_vec = 0;
  int n_bad = 0;

  sar_serial_seq i_sar_serial_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .result_in(result_in),
    .dout(dout), .dout_oe(dout_oe), .analog_pd(analog_pd), .full_sd(full_sd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic fall_edge();
    sclk = 1'b1;
    settle();
    sclk = 1'b0;
    settle();
  endtask

  // stop_at = 0 runs a full cycle plus trailing edges; otherwise chip select
  // rises after that many falling edges (short cycle, R7).
  task automatic conv(input logic [15:0] w, input int stop_at);
    logic eo, ed, ep;
    result_in = w;
    cs_n = 1'b0;
    settle();
    chk("R1 full_sd", {15'd0, full_sd}, 16'd0);
    chk("R1 analog_pd", {15'd0, analog_pd}, 16'd0);
    chk("R1 dout_oe", {15'd0, dout_oe}, 16'd0);
    for (int k = 1; k <= 40; k++) begin
      fall_edge();
      eo = (k >= 5) && (k <= 36);
      ed = 1'b0;
      if (k >= 6 && k <= 21) ed = w[21-k];
      else if (k >= 22 && k <= 36) ed = w[k-21];
      ep = (k >= 21);
      if (k < 5) chk("R2 oe in sample window", {15'd0, dout_oe}, 16'd0);
      else if (k == 5) begin
        chk("R3 null oe", {15'd0, dout_oe}, 16'd1);
        chk("R3 null bit", {15'd0, dout}, 16'd0);
        result_in = ~w;  // R10: must not reach the output
      end else if (k <= 21) begin
        chk("R4/R9/R10 msb-first oe", {15'd0, dout_oe}, 16'd1);
        chk("R4/R9/R10 msb-first bit", {15'd0, dout}, {15'd0, ed});
      end else begin
        chk("R5 lsb-first or done oe", {15'd0, dout_oe}, {15'd0, eo});
        if (eo) chk("R5/R10 lsb-first bit", {15'd0, dout}, {15'd0, ed});
      end
      chk("R8 analog_pd", {15'd0, analog_pd}, {15'd0, ep});
      chk("R8 full_sd low", {15'd0, full_sd}, 16'd0);
      if (stop_at == k) begin
        cs_n = 1'b1;
        settle();
        chk("R7 abort oe", {15'd0, dout_oe}, 16'd0);
        chk("R7 abort shutdown", {15'd0, full_sd}, 16'd1);
        settle();
        return;
      end
    end
    // R6: chip select held low after finishing: no restart
    settle();
    chk("R6 no restart while low", {15'd0, dout_oe}, 16'd0);
    chk("R6 still powered-down", {15'd0, analog_pd}, 16'd1);
    cs_n = 1'b1;
    settle();
    chk("R6 shutdown", {15'd0, full_sd}, 16'd1);
    chk("R6 tristate", {15'd0, dout_oe}, 16'd0);
    chk("R8 pd with cs high", {15'd0, analog_pd}, 16'd1);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    result_in = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    chk("R6 reset oe", {15'd0, dout_oe}, 16'd0);
    chk("R6 reset shutdown", {15'd0, full_sd}, 16'd1);
    chk("R8 reset pd", {15'd0, analog_pd}, 16'd1);

    conv(16'h0000, 0);   // R9 zero
    conv(16'hFFFF, 0);   // R9 full scale
    conv(16'h8000, 0);
    conv(16'h7FFF, 0);
    conv(16'hA5C3, 0);
    for (int b = 0; b < 16; b++) conv(16'(1) << b, 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      conv(lfsr, 0);
    end
    // R7 short cycles at several points, each followed by a full cycle
    conv(16'h1234, 3);
    conv(16'h1234, 0);
    conv(16'hBEEF, 5);
    conv(16'hBEEF, 0);
    conv(16'hC0DE, 12);
    conv(16'h5A5A, 21);
    conv(16'h0F0F, 30);
    conv(16'hF0F0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule